// File: doc/BRIEF.md
# Dual Stepper Angle Command Controller

This block turns absolute angle commands from a host into step and direction signals for two stepper motor drivers. The host writes a 9-bit word with a strobe. The upper bit picks the motor, and the lower byte gives the target angle in whole degrees. Each motor keeps two registers: the target it was told to reach and the angle it is at now. The sign of their difference sets the direction. The block then issues one square pulse per degree until the two registers agree.

A new target can arrive while a motor is moving. The motor finishes any pulse that is already high. It then heads for the new target, reversing when needed. A homing request sends both motors back to the 60-degree home angle. Step speed comes from a clock divider parameter. The direction line settles for one full step period before the first pulse in a new direction. A shared driver enable is active while either motor is away from its target.

Top module: `dual_stepper_ctrl`

## Requirements
- R1: On a clock edge with `cmd_wr` high, `cmd_data[7:0]` becomes the target of motor 1 when `cmd_data[8]` is 1 and of motor 0 when it is 0; the other motor is untouched.
- R2: A written angle above 120 is stored as 120; 120 itself is kept.
- R3: After reset both current angles and targets are 60, and `step_o`, `busy_o` and `drv_en` are low.
- R4: Every step pulse moves the current angle by exactly one degree. A move ends with the current angle equal to the target, after |target − start| pulses.
- R5: `dir_o` is 1 for increasing angle and 0 for decreasing, and it does not change while `step_o` is high.
- R6: After `dir_o` is set for a move, no step pulse rises for at least one step period (2·HALF_DIV cycles).
- R7: Each step pulse is high for HALF_DIV cycles, and rising edges are at least 2·HALF_DIV cycles apart.
- R8: A target written during a move pre-empts it, and the motor ends at the newest target, whether that lies ahead or behind.
- R9: A cycle with `home_req` high sets both targets to 60, and it overrides a `cmd_wr` in the same cycle.
- R10: `busy_o[i]` is high exactly while motor i's current angle differs from its target, and `drv_en` is the OR of both busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 9 | Bit 8 motor select, bits 7:0 target angle |
| home_req | input | 1 | Send both motors to the home angle |
| step_o | output | 2 | Step pulse per motor |
| dir_o | output | 2 | Direction per motor (1 = increasing) |
| drv_en | output | 1 | Shared driver enable |
| busy_o | output | 2 | Motor away from its target |

## Verification
The core function is tried with five kinds of move: upward and downward moves from rest, a target above the clamp limit, a target equal to the current angle, and writes that land mid-move. The upward and downward moves separate the two direction values. The no-move write shows that an equal target issues no pulse. The mid-move writes come in two forms, one that keeps the current direction and one that reverses it. Together they show that the newest target wins and that a reversal waits out the settle period. Homing combined with a simultaneous write shows which source has priority.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;
  localparam int ANG_W  = 8;
  localparam int NUM_AX = 2;

  typedef enum logic [1:0] {AX_IDLE, AX_SETTLE, AX_RUN} ax_state_t;

  // limit a requested angle to the travel range
  function automatic logic [ANG_W-1:0] clamp_angle(input logic [ANG_W-1:0] req,
                                                   input logic [ANG_W-1:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  // one degree along the chosen direction
  function automatic logic [ANG_W-1:0] step_next(input logic [ANG_W-1:0] cur,
                                                 input logic up);
    return up ? cur + 1'b1 : cur - 1'b1;
  endfunction
endpackage

// File: rtl/stepctl_decode.sv
module stepctl_decode
  import stepctl_pkg::*;
#(
  parameter logic [ANG_W-1:0] MAX_ANG  = 8'd120,
  parameter logic [ANG_W-1:0] HOME_ANG = 8'd60
) (
  input  logic                          wr,
  input  logic [ANG_W:0]                data,
  input  logic                          home,
  output logic [NUM_AX-1:0]             load,
  output logic [NUM_AX-1:0][ANG_W-1:0]  load_val
);
  logic [ANG_W-1:0] limited;
  assign limited = clamp_angle(data[ANG_W-1:0], MAX_ANG);

  for (genvar i = 0; i < NUM_AX; i++) begin : g_sel
    assign load[i]     = home | (wr & (data[ANG_W] == 1'(i)));
    assign load_val[i] = home ? HOME_ANG : limited;
  end
endmodule

// File: rtl/step_axis.sv
module step_axis
  import stepctl_pkg::*;
#(
  parameter int               HALF_DIV = 4,
  parameter logic [ANG_W-1:0] HOME_ANG = 8'd60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ANG_W-1:0] load_val,
  output logic             step,
  output logic             dir,
  output logic             busy,
  output logic [ANG_W-1:0] cur,
  output logic [ANG_W-1:0] tgt,
  output logic             pulse_done
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW     = $clog2(PERIOD + 1);

  ax_state_t        st;
  logic [CW-1:0]    cnt;
  logic [ANG_W-1:0] tgt_q, cur_q;
  logic             dir_q;

  logic want_up, at_tgt, cnt_end, half_end;
  assign want_up  = tgt_q > cur_q;
  assign at_tgt   = tgt_q == cur_q;
  assign cnt_end  = cnt == CW'(PERIOD - 1);
  assign half_end = cnt == CW'(HALF_DIV - 1);

  assign pulse_done = (st == AX_RUN) && half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= HOME_ANG;
    else if (load) tgt_q <= load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= AX_IDLE;
      cnt   <= '0;
      cur_q <= HOME_ANG;
      dir_q <= 1'b0;
    end else begin
      unique case (st)
        AX_IDLE: begin
          cnt <= '0;
          if (!at_tgt) begin
            dir_q <= want_up;
            st    <= AX_SETTLE;
          end
        end
        AX_SETTLE: begin
          if (cnt_end) begin
            cnt <= '0;
            if (at_tgt) st <= AX_IDLE;
            else if (want_up != dir_q) dir_q <= want_up;  // settle again
            else st <= AX_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        AX_RUN: begin
          if (pulse_done) cur_q <= step_next(cur_q, dir_q);
          if (cnt_end) begin
            cnt <= '0;
            if (at_tgt) st <= AX_IDLE;
            else if (want_up != dir_q) begin
              dir_q <= want_up;
              st    <= AX_SETTLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= AX_IDLE;
      endcase
    end
  end

  assign step = (st == AX_RUN) && (cnt < CW'(HALF_DIV));
  assign dir  = dir_q;
  assign busy = !at_tgt;
  assign cur  = cur_q;
  assign tgt  = tgt_q;
endmodule

// File: rtl/dual_stepper_ctrl.sv
module dual_stepper_ctrl
  import stepctl_pkg::*;
#(
  parameter int               HALF_DIV = 4,
  parameter logic [ANG_W-1:0] MAX_ANG  = 8'd120,
  parameter logic [ANG_W-1:0] HOME_ANG = 8'd60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [ANG_W:0]       cmd_data,
  input  logic                 home_req,
  output logic [NUM_AX-1:0]    step_o,
  output logic [NUM_AX-1:0]    dir_o,
  output logic                 drv_en,
  output logic [NUM_AX-1:0]    busy_o
);
  logic [NUM_AX-1:0]            load_w;
  logic [NUM_AX-1:0][ANG_W-1:0] load_val_w;
  logic [NUM_AX-1:0][ANG_W-1:0] cur_w, tgt_w;
  logic [NUM_AX-1:0]            pulse_done_w;

  stepctl_decode #(.MAX_ANG(MAX_ANG), .HOME_ANG(HOME_ANG)) u_dec (
    .wr(cmd_wr), .data(cmd_data), .home(home_req),
    .load(load_w), .load_val(load_val_w)
  );

  for (genvar i = 0; i < NUM_AX; i++) begin : g_ax
    step_axis #(.HALF_DIV(HALF_DIV), .HOME_ANG(HOME_ANG)) u_ax (
      .clk(clk), .rst_n(rst_n),
      .load(load_w[i]), .load_val(load_val_w[i]),
      .step(step_o[i]), .dir(dir_o[i]), .busy(busy_o[i]),
      .cur(cur_w[i]), .tgt(tgt_w[i]), .pulse_done(pulse_done_w[i])
    );
  end

  assign drv_en = |busy_o;
endmodule

// File: rtl/stepctl_chk.sv
module stepctl_chk
  import stepctl_pkg::*;
#(
  parameter int               HALF_DIV = 4,
  parameter logic [ANG_W-1:0] MAX_ANG  = 8'd120,
  parameter logic [ANG_W-1:0] HOME_ANG = 8'd60
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         home_req,
  input logic [NUM_AX-1:0]            step_o,
  input logic [NUM_AX-1:0]            dir_o,
  input logic [NUM_AX-1:0][ANG_W-1:0] cur_w,
  input logic [NUM_AX-1:0][ANG_W-1:0] tgt_w,
  input logic [NUM_AX-1:0]            pulse_done_w
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int GW     = $clog2(PERIOD + 1);

  for (genvar i = 0; i < NUM_AX; i++) begin : g_chk
    logic          dir_q;
    logic [GW-1:0] gap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= 1'b0;
        gap   <= GW'(PERIOD);
      end else begin
        dir_q <= dir_o[i];
        if (dir_o[i] != dir_q) gap <= '0;
        else if (gap != GW'(PERIOD)) gap <= gap + 1'b1;
      end
    end

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_w[i] <= MAX_ANG) && (cur_w[i] <= MAX_ANG));

    p_cur_moves_only_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_done_w[i] |=> $stable(cur_w[i]));

    p_cur_one_degree_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_done_w[i] |=> (cur_w[i] == step_next($past(cur_w[i]), $past(dir_o[i]))));

    p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o[i] && $past(step_o[i])) |-> $stable(dir_o[i]));

    p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_o[i]) |-> (gap >= GW'(PERIOD - 1)));

    p_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
      home_req |=> (tgt_w[i] == HOME_ANG));
  end
endmodule

bind dual_stepper_ctrl stepctl_chk #(
  .HALF_DIV(HALF_DIV), .MAX_ANG(MAX_ANG), .HOME_ANG(HOME_ANG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .home_req(home_req),
  .step_o(step_o), .dir_o(dir_o),
  .cur_w(cur_w), .tgt_w(tgt_w), .pulse_done_w(pulse_done_w)
);

// File: tb/sim_dual_stepper_ctrl.sv
module sim_dual_stepper_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int STEP_PER = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [8:0] cmd_data = '0;
  logic       home_req = 1'b0;
  logic [1:0] step_o, dir_o, busy_o;
  logic       drv_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int pos[2];
  int rises[2];
  int hi_len[2];
  int since_dir[2];
  int since_rise[2];
  logic prev_step[2];
  logic prev_dir[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stepper_ctrl #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .home_req(home_req), .step_o(step_o), .dir_o(dir_o),
    .drv_en(drv_en), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent pulse monitor: tracks position, widths and settle gaps
  initial begin
    for (int m = 0; m < 2; m++) begin
      pos[m] = 60; rises[m] = 0; hi_len[m] = 0;
      since_dir[m] = 1000; since_rise[m] = 1000;
      prev_step[m] = 1'b0; prev_dir[m] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        if (dir_o[m] != prev_dir[m]) begin
          if (prev_step[m] && step_o[m])
            check(0, "R5 dir changed during high pulse", int'(dir_o[m]), int'(prev_dir[m]));
          since_dir[m] = 0;
        end else begin
          since_dir[m]++;
        end
        since_rise[m]++;
        if (step_o[m] && !prev_step[m]) begin
          check(since_dir[m] >= STEP_PER, "R6 settle before first pulse", since_dir[m], STEP_PER);
          check(since_rise[m] >= STEP_PER, "R7 pulse spacing", since_rise[m], STEP_PER);
          since_rise[m] = 0;
          pos[m] += dir_o[m] ? 1 : -1;
          rises[m]++;
          hi_len[m] = 1;
        end else if (step_o[m]) begin
          hi_len[m]++;
        end else if (prev_step[m]) begin
          check(hi_len[m] == HALF, "R7 pulse high width", hi_len[m], HALF);
        end
        prev_step[m] = step_o[m];
        prev_dir[m]  = dir_o[m];
      end
      if (drv_en != (busy_o[0] | busy_o[1]))
        check(0, "R10 drv_en vs busy", int'(drv_en), int'(busy_o[0] | busy_o[1]));
    end
  end

  task automatic send(input bit mot, input int ang);
    @(negedge clk);
    cmd_data = {mot, 8'(ang)};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5000; k++) begin
      if (busy_o == 2'b00 && step_o == 2'b00) break;
      @(negedge clk);
    end
    repeat (STEP_PER) @(negedge clk);
  endtask

  task automatic wait_pulses(input int m, input int n);
    int base = rises[m];
    for (int k = 0; k < 5000; k++) begin
      if (rises[m] >= base + n) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(step_o == 2'b00, "R3 step low after reset", int'(step_o), 0);
    check(busy_o == 2'b00, "R3 busy low after reset", int'(busy_o), 0);
    check(drv_en == 1'b0, "R3 enable low after reset", int'(drv_en), 0);
    send(0, 60);
    wait_idle();
    check(rises[0] == 0, "R3 home angle is 60 (no pulses for 60)", rises[0], 0);
  endtask

  task automatic t_basic_up();
    int r0 = rises[0];
    send(0, 90);
    repeat (2) @(negedge clk);
    check(busy_o[0] == 1'b1, "R10 busy during move", int'(busy_o[0]), 1);
    check(drv_en == 1'b1, "R10 enable during move", int'(drv_en), 1);
    check(dir_o[0] == 1'b1, "R5 dir up", int'(dir_o[0]), 1);
    wait_idle();
    check(pos[0] == 90, "R4 motor0 reaches 90", pos[0], 90);
    check(rises[0] - r0 == 30, "R4 pulse count 30", rises[0] - r0, 30);
    check(pos[1] == 60, "R1 motor1 untouched", pos[1], 60);
    check(drv_en == 1'b0, "R10 enable off when idle", int'(drv_en), 0);
  endtask

  task automatic t_down();
    send(0, 40);
    wait_idle();
    check(pos[0] == 40, "R4 motor0 reaches 40", pos[0], 40);
    check(dir_o[0] == 1'b0, "R5 dir down", int'(dir_o[0]), 0);
  endtask

  task automatic t_motor1();
    send(1, 100);
    wait_idle();
    check(pos[1] == 100, "R1 motor1 reaches 100", pos[1], 100);
    check(pos[0] == 40, "R1 motor0 untouched", pos[0], 40);
  endtask

  task automatic t_clamp();
    int r0;
    send(0, 200);
    wait_idle();
    check(pos[0] == 120, "R2 clamp 200 to 120", pos[0], 120);
    r0 = rises[0];
    send(0, 120);
    wait_idle();
    check(rises[0] == r0, "R2 120 kept, no pulses", rises[0] - r0, 0);
    check(busy_o[0] == 1'b0, "R10 busy low at target", int'(busy_o[0]), 0);
  endtask

  task automatic t_preempt_reverse();
    send(1, 30);
    wait_pulses(1, 10);
    send(1, 110);
    wait_idle();
    check(pos[1] == 110, "R8 reverse pre-empt ends at 110", pos[1], 110);
    check(dir_o[1] == 1'b1, "R8 dir reversed to up", int'(dir_o[1]), 1);
  endtask

  task automatic t_preempt_same();
    send(0, 40);
    wait_pulses(0, 5);
    send(0, 90);
    wait_idle();
    check(pos[0] == 90, "R8 same-direction pre-empt ends at 90", pos[0], 90);
    check(dir_o[0] == 1'b0, "R8 dir stays down", int'(dir_o[0]), 0);
  endtask

  task automatic t_home();
    send(0, 10);
    wait_idle();
    @(negedge clk);
    cmd_data = {1'b1, 8'd5};
    cmd_wr = 1'b1;
    home_req = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    home_req = 1'b0;
    wait_idle();
    check(pos[0] == 60, "R9 motor0 homed", pos[0], 60);
    check(pos[1] == 60, "R9 motor1 homed, write overridden", pos[1], 60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_up();
    t_down();
    t_motor1();
    t_clamp();
    t_preempt_reverse();
    t_preempt_same();
    t_home();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule